// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

The engine copies bytes from one place on the system bus to another so the processor does not have to. Firmware loads a source pointer, a destination pointer and a byte count. It then writes a control word that picks the transfer policy, marks each side as memory or I/O, selects what happens when the count runs out, and arms the channel.

When a transfer is due, the engine raises a bus request. It waits for the processor's grant and lets one clock pass so the processor can float its pins. Only then does it drive address, data and strobes.

Three policies share one sequencer:
- **Cycle stealing:** each peripheral ready pulse moves one byte.
- **Burst:** one trigger moves the whole block while the bus is held.
- **Flyby:** a single combined read/write cycle per byte. Only the memory side gets an address, and a fixed port supplies or takes the data.

At the end of a block the engine stops, stops and raises a level interrupt, or restores its starting values and waits for the next ready pulse.

Top module: `dma_engine`

## Requirements
- R1: Register index 0 is the source pointer, 1 the destination pointer, 2 the count and 3 the control word. The control word bits are:
  - write: [1:0] policy (0 cycle stealing, 1 or 3 burst, 2 flyby); [2] source is I/O; [3] destination is I/O; [5:4] completion action (0 stop, 1 interrupt, 2 reload); [6] start; [7] interrupt clear; [8] burst and flyby wait for a ready pulse.
  - read: the written configuration, with busy at [14] and the interrupt at [15].
  - After reset all registers read zero, and the interrupt and the request are low.
- R2: The engine drives the bus only while both its request and the grant are high. It drops its drivers in the same clock that it drops the request.
- R3: After the grant first appears, at least one full clock passes with the drivers off before the first bus cycle.
- R4: Outside flyby, each byte is a read cycle at the source address followed in the next clock by a write cycle that carries the byte just read to the destination address.
- R5: After each byte the count falls by one. A memory-side pointer rises by one, and an I/O-side pointer keeps its value.
- R6: In cycle stealing, each ready pulse moves exactly one byte under its own request, and the bus is released between bytes.
- R7: In burst, a start with [8] clear (or a ready pulse when [8] is set) moves the whole block under a single request. With [8] set, nothing is requested before the pulse.
- R8: In flyby, each byte is one cycle with read, write and the flyby flag all high. The address is the memory-side pointer, so exactly one side must be I/O.
- R9: At count exhaustion, action 0 goes idle, action 1 goes idle and raises the interrupt, and action 2 restores the starting pointers and count, stays busy and waits for a ready pulse.
- R10: The interrupt is a level that stays high until a control write with [7] set.
- R11: A start with a count of zero never requests the bus. It completes at once and raises the interrupt if action 1 is chosen.
- R12: While busy, writes to the pointers, the count and the configuration have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for reg_addr |
| periph_rdy | input | 1 | Peripheral ready pulse |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_drive | output | 1 | Engine is driving the bus |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | Current cycle targets I/O space |
| bus_fly | output | 1 | Flyby cycle; the fixed port takes part |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench sweeps every policy over every legal pair of memory and I/O sides, at counts of zero, one and several. For each run it checks the copied bytes, the final pointers and the number of separate bus requests.
- A design that counted one byte too many would corrupt the byte just past the destination block.
- Updating an I/O pointer would scatter port data across addresses.
- Releasing the bus between burst bytes would show up as extra requests.
- Dropping the settle clock would start a read in the same cycle the grant appears.

Separate runs cover:
- Reload, where a lost shadow copy would leave the count at zero.
- A burst that must wait for the ready pulse, where a premature request would appear before the pulse.
- Register writes during a transfer, which must not move the pointers.
- Clearing the interrupt, which must stay high until that write arrives.

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          periph_rdy,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_drive,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic          bus_fly,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [1:0] P_STEAL = 2'd0, P_FLY = 2'd2;
  localparam logic [1:0] A_IRQ = 2'd1, A_RELOAD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_REQ, S_SET, S_RD, S_WR, S_FLY} st_t;
  st_t state;

  logic [AW-1:0] src, dst, cnt, src0, dst0, cnt0;
  logic [DW-1:0] data_q;
  logic [1:0]    pol, act;
  logic          sio, dio, waitrdy, irq_q;

  wire busy   = state != S_IDLE;
  wire ctl_wr = reg_we && reg_addr == 2'd3;
  wire last   = cnt == AW'(1);
  wire [15:0] ctl_view = {irq_q, busy, 5'd0, waitrdy, 2'd0, act, dio, sio, pol};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = src;
      2'd1:    reg_rdata = dst;
      2'd2:    reg_rdata = cnt;
      default: reg_rdata = AW'(ctl_view);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      src <= '0; dst <= '0; cnt <= '0;
      src0 <= '0; dst0 <= '0; cnt0 <= '0;
      data_q <= '0; pol <= '0; act <= '0;
      sio <= 1'b0; dio <= 1'b0; waitrdy <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (ctl_wr && reg_wdata[7]) irq_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reg_we && reg_addr == 2'd0) src <= reg_wdata;
          if (reg_we && reg_addr == 2'd1) dst <= reg_wdata;
          if (reg_we && reg_addr == 2'd2) cnt <= reg_wdata;
          if (ctl_wr) begin
            pol <= reg_wdata[1:0];
            sio <= reg_wdata[2];
            dio <= reg_wdata[3];
            act <= reg_wdata[5:4];
            waitrdy <= reg_wdata[8];
            if (reg_wdata[6]) begin
              src0 <= src; dst0 <= dst; cnt0 <= cnt;
              if (cnt == '0) begin
                if (reg_wdata[5:4] == A_IRQ) irq_q <= 1'b1;
              end else if (reg_wdata[1:0] != P_STEAL && !reg_wdata[8])
                state <= S_REQ;
              else
                state <= S_ARM;
            end
          end
        end
        S_ARM: if (periph_rdy) state <= S_REQ;
        S_REQ: if (bus_gnt) state <= S_SET;
        S_SET: state <= (pol == P_FLY) ? S_FLY : S_RD;
        S_RD: begin
          data_q <= bus_rdata;
          state <= S_WR;
        end
        default: begin
          cnt <= cnt - AW'(1);
          if (!sio) src <= src + AW'(1);
          if (!dio) dst <= dst + AW'(1);
          if (last) begin
            state <= S_IDLE;
            if (act == A_IRQ) irq_q <= 1'b1;
            if (act == A_RELOAD) begin
              src <= src0; dst <= dst0; cnt <= cnt0;
              state <= S_ARM;
            end
          end else if (pol == P_STEAL)
            state <= S_ARM;
          else
            state <= (pol == P_FLY) ? S_FLY : S_RD;
        end
      endcase
    end
  end

  assign bus_req   = state inside {S_REQ, S_SET, S_RD, S_WR, S_FLY};
  assign bus_drive = state inside {S_RD, S_WR, S_FLY};
  assign bus_rd    = state == S_RD || state == S_FLY;
  assign bus_wr    = state == S_WR || state == S_FLY;
  assign bus_fly   = state == S_FLY;
  assign bus_io    = (state == S_RD && sio) || (state == S_WR && dio);
  assign bus_wdata = (state == S_WR) ? data_q : '0;
  assign irq       = irq_q;

  always_comb begin
    case (state)
      S_RD:    bus_addr = src;
      S_WR:    bus_addr = dst;
      S_FLY:   bus_addr = sio ? dst : src;
      default: bus_addr = '0;
    endcase
  end
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [AW-1:0] reg_wdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_drive,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_fly,
  input logic          irq
);
  AST_DRIVE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (bus_req && bus_gnt)); // R2
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> !bus_drive); // R2
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_gnt) |=> !bus_drive); // R3
  AST_SETTLE_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> ($past(bus_gnt) && $past(bus_req))); // R3
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_fly) |=> (bus_wr && !bus_rd)); // R4
  AST_FLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |-> bus_fly); // R8
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && reg_addr == 2'd3 && reg_wdata[7])) |=> irq); // R10
endmodule

bind dma_engine dma_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_drive(bus_drive), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_fly(bus_fly), .irq(irq)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [AW-1:0] SRC_BASE = 16'h0010, DST_BASE = 16'h0080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, periph_rdy = 1'b0, bus_gnt = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [AW-1:0] reg_wdata = '0, reg_rdata, bus_addr;
  logic bus_req, bus_drive, bus_rd, bus_wr, bus_io, bus_fly, irq;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic [7:0] mem [256];
  logic [7:0] plog [16];
  int prd, pw, reqs, drives;
  logic mem_init = 1'b0, cur_sio = 1'b0, prev_req = 1'b0;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_rdy(periph_rdy),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_drive(bus_drive),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_fly(bus_fly), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7) + 3);
  endfunction

  assign bus_rdata = bus_io ? 8'(8'hA0 + prd) : mem[bus_addr[7:0]];

  always @(posedge clk) begin
    bus_gnt <= rst_n ? bus_req : 1'b0;
    prev_req <= bus_req;
    if (mem_init) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      for (int i = 0; i < 16; i++) plog[i] <= 8'h00;
      prd <= 0; pw <= 0; reqs <= 0; drives <= 0;
    end else begin
      if (bus_req && !prev_req) reqs <= reqs + 1;
      if (bus_drive) drives <= drives + 1;
      if (bus_fly) begin
        if (cur_sio) begin mem[bus_addr[7:0]] <= 8'(8'hA0 + prd); prd <= prd + 1; end
        else begin plog[pw[3:0]] <= mem[bus_addr[7:0]]; pw <= pw + 1; end
      end else begin
        if (bus_rd && bus_io) prd <= prd + 1;
        if (bus_wr) begin
          if (bus_io) begin plog[pw[3:0]] <= bus_wdata; pw <= pw + 1; end
          else mem[bus_addr[7:0]] <= bus_wdata;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [AW-1:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_rdy();
    @(negedge clk); periph_rdy = 1'b1;
    @(negedge clk); periph_rdy = 1'b0;
  endtask

  task automatic fresh(input logic s);
    cur_sio = s;
    @(negedge clk); mem_init = 1'b1;
    @(negedge clk); mem_init = 1'b0;
  endtask

  function automatic logic [AW-1:0] ctl(int p, int s, int d, int a, int st, int w);
    return AW'(p | (s << 2) | (d << 3) | (a << 4) | (st << 6) | (w << 8) | 128);
  endfunction

  task automatic run(input int p, input int s, input int d, input int a, input int n);
    logic [AW-1:0] v;
    logic [7:0] got, exp;
    fresh(s[0]);
    wr(2'd3, ctl(0, 0, 0, 0, 0, 0));
    wr(2'd0, SRC_BASE); wr(2'd1, DST_BASE); wr(2'd2, AW'(n));
    wr(2'd3, ctl(p, s, d, a, 1, 0));
    if (p == 0) for (int k = 0; k < n; k++) begin pulse_rdy(); repeat (8) @(negedge clk); end
    repeat (30) @(negedge clk);
    rd(2'd3, v);
    check("R9 busy cleared", v[14], 0);
    check(n == 0 ? "R11 zero-count irq" : "R9 irq by action", v[15], a == 1);
    check(n == 0 ? "R11 no request" : (p == 0 ? "R6 request per byte" : "R7 single request"),
          reqs, n == 0 ? 0 : (p == 0 ? n : 1));
    check(p == 2 ? "R8 one cycle per byte" : "R4 two cycles per byte", drives, p == 2 ? n : 2 * n);
    rd(2'd2, v); check("R5 count exhausted", v, 0);
    rd(2'd0, v); check("R5 source pointer", v, SRC_BASE + (s ? 0 : n));
    rd(2'd1, v); check("R5 destination pointer", v, DST_BASE + (d ? 0 : n));
    for (int k = 0; k < n; k++) begin
      exp = s ? 8'(8'hA0 + k) : init_val(int'(SRC_BASE) + k);
      got = d ? plog[k] : mem[int'(DST_BASE) + k];
      check(p == 2 ? "R8 flyby data" : "R4 copied data", got, exp);
    end
    if (!d) check("R5 no overrun", mem[int'(DST_BASE) + n], init_val(int'(DST_BASE) + n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      rd(r[1:0], v); check("R1 reset value", v, 0);
    end
    check("R1 reset irq", irq, 0);
    check("R1 reset request", bus_req, 0);
    wr(2'd0, 16'h1234); rd(2'd0, v); check("R1 source readback", v, 16'h1234);
    wr(2'd3, AW'(16'h012E)); rd(2'd3, v); check("R1 control readback", v, 16'h012E);

    for (int p = 0; p < 3; p++)
      for (int sd = 0; sd < 4; sd++)
        for (int ni = 0; ni < 4; ni++) begin
          if (p == 2 && (sd == 0 || sd == 3)) continue;
          run(p, sd & 1, sd >> 1, (ni + sd) % 2, ni == 0 ? 0 : 2 * ni - 1);
        end

    run(0, 0, 0, 1, 2);
    repeat (20) @(negedge clk);
    check("R10 irq held", irq, 1);
    wr(2'd3, ctl(0, 0, 0, 0, 0, 0));
    #1 check("R10 irq cleared", irq, 0);

    fresh(1'b0);
    wr(2'd0, SRC_BASE); wr(2'd1, DST_BASE); wr(2'd2, AW'(2));
    wr(2'd3, ctl(0, 0, 0, 0, 1, 0));
    wr(2'd0, 16'h0055); wr(2'd2, AW'(9)); wr(2'd3, ctl(1, 1, 1, 1, 0, 0));
    rd(2'd0, v); check("R12 source write ignored", v, SRC_BASE);
    rd(2'd2, v); check("R12 count write ignored", v, 2);
    rd(2'd3, v); check("R12 busy and config kept", v, 16'h4000);
    pulse_rdy(); repeat (8) @(negedge clk);
    pulse_rdy(); repeat (8) @(negedge clk);
    check("R6 steal requests", reqs, 2);
    check("R12 data after ignored writes", mem[int'(DST_BASE) + 1], init_val(int'(SRC_BASE) + 1));

    fresh(1'b0);
    wr(2'd0, SRC_BASE); wr(2'd1, DST_BASE); wr(2'd2, AW'(2));
    wr(2'd3, ctl(1, 0, 0, 0, 1, 1));
    repeat (10) @(negedge clk);
    check("R7 no request before ready", reqs, 0);
    pulse_rdy(); repeat (20) @(negedge clk);
    check("R7 ready-triggered burst", reqs, 1);
    check("R7 burst data", mem[int'(DST_BASE) + 1], init_val(int'(SRC_BASE) + 1));

    fresh(1'b0);
    wr(2'd0, SRC_BASE); wr(2'd1, DST_BASE); wr(2'd2, AW'(3));
    wr(2'd3, ctl(1, 0, 0, 2, 1, 0));
    repeat (30) @(negedge clk);
    rd(2'd3, v); check("R9 reload stays busy", v[14], 1);
    rd(2'd2, v); check("R9 reload count", v, 3);
    rd(2'd0, v); check("R9 reload source", v, SRC_BASE);
    check("R9 reload no irq", irq, 0);
    check("R9 reload waits", reqs, 1);
    pulse_rdy(); repeat (30) @(negedge clk);
    check("R9 second block request", reqs, 2);
    check("R9 second block cycles", drives, 12);
    rd(2'd1, v); check("R9 reload destination", v, DST_BASE);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule